// File: doc/BRIEF.md
# Multi-Driver Strength Resolver

This block decides what a shared node carries when several sources drive it at once. Each of `N` driver ports offers one logic bit and a 3-bit strength level. The block ranks the levels, keeps only the drivers at the highest level present, and reports the node as 0, 1, Z or X. It also reports the level at which that value holds.

The block is purely combinational, with no clock and no state. It suits a behavioural model of a contended net, a keeper or bus checker, or any unit that has to settle a fight between drivers of unequal force. Charge levels (large, medium and small) rank on the same scale as the driving levels. Level 0 means the port is not driving.

The block first finds the peak level with a balanced maximum tree. It then looks at the values held at that peak. Because of this, the answer does not depend on which port a driver sits on.

Top module: `strres_node`

## Requirements
- R1: Strength levels are 3-bit numbers, where a higher number is stronger: 7 supply, 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small, 0 highz. `node_lvl` always equals the highest level found on any driver, and charge levels take part in this ranking like any other level.
- R2: When exactly one driver holds the highest level, `node_val` gives that driver's value and `node_lvl` gives its level.
- R3: When several drivers share the highest level and all carry the same value, the node keeps that value at that level.
- R4: When drivers at the highest level carry both 0 and 1, `node_val` is X (2'b11) and `node_lvl` is that level.
- R5: A driver at level 0 has no effect. Its value bit is ignored, and any driver above level 0 overrides it.
- R6: When every driver is at level 0, `node_val` is Z (2'b10) and `node_lvl` is 0.
- R7: A supply-level driver beats every non-supply driver. For example, supply 0 against strong 1 gives 0 at level 7.
- R8: A pull-level keeper loses to a strong driver. For example, strong 0 against pull 1 gives 0 at level 6.
- R9: The result does not change when drivers are moved to different port positions.
- R10: `node_val` is encoded as 2'b00 = 0, 2'b01 = 1, 2'b10 = Z and 2'b11 = X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_val | input | N | Value bit of each driver; bit k belongs to driver k |
| drv_lvl | input | 3*N | Strength level of each driver; bits [3k+2:3k] belong to driver k |
| node_val | output | 2 | Resolved node value: 00 = 0, 01 = 1, 10 = Z, 11 = X |
| node_lvl | output | 3 | Strength level of the resolved value |

## Verification
Both results are combinational, so each one is due within the same bench cycle in which its stimulus is applied. The bench applies a driver pattern on a rising clock edge and queues the expected value and level at that moment. The monitor takes the queued item off at the next falling edge, half a period later, once the logic has settled. Every queued item therefore meets exactly one pattern. Expected values come either from constants written out from the requirements or from a pairwise fold over the ports, which the design does not use.

// File: rtl/strres_pkg.sv
package strres_pkg;

  localparam int LVL_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  // Ranking: higher code is stronger.
  localparam lvl_t LVL_HIGHZ  = 3'd0;
  localparam lvl_t LVL_SMALL  = 3'd1;
  localparam lvl_t LVL_MEDIUM = 3'd2;
  localparam lvl_t LVL_WEAK   = 3'd3;
  localparam lvl_t LVL_LARGE  = 3'd4;
  localparam lvl_t LVL_PULL   = 3'd5;
  localparam lvl_t LVL_STRONG = 3'd6;
  localparam lvl_t LVL_SUPPLY = 3'd7;

  typedef enum logic [1:0] {
    NODE_0 = 2'b00,
    NODE_1 = 2'b01,
    NODE_Z = 2'b10,
    NODE_X = 2'b11
  } node_t;

  // Larger of two levels.
  function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction

  // Node value from the values observed at the peak level.
  function automatic node_t node_pick(input logic seen0, input logic seen1,
                                      input lvl_t peak);
    if (peak == LVL_HIGHZ) return NODE_Z;
    if (seen0 && seen1)    return NODE_X;
    if (seen1)             return NODE_1;
    return NODE_0;
  endfunction

endpackage

// File: rtl/strres_peak.sv
module strres_peak
  import strres_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N*LVL_W-1:0] drv_lvl,
  output lvl_t               peak_lvl
);

  localparam int DEPTH  = (N > 1) ? $clog2(N) : 0;
  localparam int LEAVES = 1 << DEPTH;

  // Balanced max tree; stage s holds LEAVES>>s partial maxima.
  for (genvar s = 0; s <= DEPTH; s++) begin : g_stage
    localparam int W = LEAVES >> s;
    logic [W*LVL_W-1:0] v;
    if (s == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_in
        if (k < N) begin : g_real
          assign v[k*LVL_W +: LVL_W] = drv_lvl[k*LVL_W +: LVL_W];
        end else begin : g_pad
          assign v[k*LVL_W +: LVL_W] = LVL_HIGHZ;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_max
        assign v[k*LVL_W +: LVL_W] =
          lvl_max(g_stage[s-1].v[(2*k)*LVL_W +: LVL_W],
                  g_stage[s-1].v[(2*k+1)*LVL_W +: LVL_W]);
      end
    end
  end

  assign peak_lvl = g_stage[DEPTH].v[LVL_W-1:0];

  // The peak bounds every driver and is attained by one of them.
  always_comb begin
    logic hit;
    hit = (peak_lvl == LVL_HIGHZ);
    for (int k = 0; k < N; k++) begin
      AST_PEAK_BOUNDS: assert (drv_lvl[k*LVL_W +: LVL_W] <= peak_lvl); // R1
      if (drv_lvl[k*LVL_W +: LVL_W] == peak_lvl) hit = 1'b1;
    end
    AST_PEAK_ATTAINED: assert (hit); // R1
  end

endmodule

// File: rtl/strres_vote.sv
module strres_vote
  import strres_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]       drv_val,
  input  logic [N*LVL_W-1:0] drv_lvl,
  input  lvl_t               peak_lvl,
  output logic [N-1:0]       at_peak,
  output logic               seen0,
  output logic               seen1
);

  // A driver votes only when it sits at the peak and actually drives.
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign at_peak[k] = (drv_lvl[k*LVL_W +: LVL_W] == peak_lvl) &&
                        (peak_lvl != LVL_HIGHZ);
  end

  assign seen0 = |(at_peak & ~drv_val);
  assign seen1 = |(at_peak &  drv_val);

  always_comb begin
    AST_VOTE_PRESENT: assert ((seen0 || seen1) == (peak_lvl != LVL_HIGHZ)); // R5
    for (int k = 0; k < N; k++) begin
      if (drv_lvl[k*LVL_W +: LVL_W] == LVL_HIGHZ)
        AST_HIGHZ_SILENT: assert (!at_peak[k]); // R5
    end
  end

endmodule

// File: rtl/strres_encode.sv
module strres_encode
  import strres_pkg::*;
(
  input  logic       seen0,
  input  logic       seen1,
  input  lvl_t       peak_lvl,
  output logic [1:0] node_val,
  output lvl_t       node_lvl
);

  assign node_val = node_pick(seen0, seen1, peak_lvl);
  assign node_lvl = peak_lvl;

  always_comb begin
    if (node_val == NODE_Z)
      AST_Z_AT_ZERO: assert (node_lvl == LVL_HIGHZ); // R6
    if (node_val == NODE_X)
      AST_X_NEEDS_BOTH: assert (seen0 && seen1); // R4
    if (seen0 && !seen1)
      AST_PLAIN_ZERO: assert (node_val == NODE_0); // R10
  end

endmodule

// File: rtl/strres_node.sv
module strres_node
  import strres_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]       drv_val,
  input  logic [N*LVL_W-1:0] drv_lvl,
  output logic [1:0]         node_val,
  output logic [LVL_W-1:0]   node_lvl
);

  lvl_t         peak_lvl;
  logic [N-1:0] at_peak;
  logic         seen0;
  logic         seen1;

  strres_peak #(.N(N)) u_peak (
    .drv_lvl (drv_lvl),
    .peak_lvl(peak_lvl)
  );

  strres_vote #(.N(N)) u_vote (
    .drv_val (drv_val),
    .drv_lvl (drv_lvl),
    .peak_lvl(peak_lvl),
    .at_peak (at_peak),
    .seen0   (seen0),
    .seen1   (seen1)
  );

  strres_encode u_enc (
    .seen0   (seen0),
    .seen1   (seen1),
    .peak_lvl(peak_lvl),
    .node_val(node_val),
    .node_lvl(node_lvl)
  );

  // Port-level relations between drivers and the resolved node.
  always_comb begin
    logic any_supply;
    logic backed;
    any_supply = 1'b0;
    backed     = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (drv_lvl[k*LVL_W +: LVL_W] == LVL_SUPPLY) any_supply = 1'b1;
      if (drv_lvl[k*LVL_W +: LVL_W] == node_lvl && node_lvl != LVL_HIGHZ &&
          node_val == {1'b0, drv_val[k]}) backed = 1'b1;
    end
    if (any_supply)
      AST_SUPPLY_WINS: assert (node_lvl == LVL_SUPPLY); // R7
    if (node_val == NODE_0 || node_val == NODE_1)
      AST_VALUE_BACKED: assert (backed); // R2
    if (|at_peak)
      AST_LEVEL_MATCH: assert (node_lvl != LVL_HIGHZ); // R1
  end

endmodule

// File: tb/sim_strres_node.sv
module sim_strres_node;

  localparam int N = 8;

  logic             clk = 1'b0;
  logic [N-1:0]     drv_val = '0;
  logic [N*3-1:0]   drv_lvl = '0;
  logic [1:0]       node_val;
  logic [2:0]       node_lvl;

  typedef struct {
    logic [1:0] ev;
    logic [2:0] el;
    string      tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [N-1:0]   v_buf;
  logic [N*3-1:0] l_buf;

  always #5 clk = ~clk;

  strres_node #(.N(N)) u0 (
    .drv_val (drv_val),
    .drv_lvl (drv_lvl),
    .node_val(node_val),
    .node_lvl(node_lvl)
  );

  // Reference: fold drivers one at a time into a running (value, level).
  function automatic logic [4:0] fold(input logic [N-1:0] v, input logic [N*3-1:0] l);
    logic [1:0] cv;
    logic [2:0] cl;
    cv = 2'b10;
    cl = 3'd0;
    for (int k = 0; k < N; k++) begin
      logic [2:0] lk;
      logic [1:0] vk;
      lk = l[k*3 +: 3];
      vk = v[k] ? 2'b01 : 2'b00;
      if (lk == 3'd0) continue;
      if (lk > cl) begin
        cv = vk;
        cl = lk;
      end else if (lk == cl && cv != vk) begin
        cv = 2'b11;
      end
    end
    return {cv, cl};
  endfunction

  task automatic clear_buf();
    v_buf = N'($urandom);
    l_buf = '0;
  endtask

  task automatic put(input int idx, input logic val, input logic [2:0] lvl);
    v_buf[idx]       = val;
    l_buf[idx*3 +: 3] = lvl;
  endtask

  task automatic drive(input logic [1:0] ev, input logic [2:0] el, input string tag);
    item_t it;
    @(posedge clk);
    drv_val <= v_buf;
    drv_lvl <= l_buf;
    it.ev = ev;
    it.el = el;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive_ref(input string tag);
    logic [4:0] r;
    r = fold(v_buf, l_buf);
    drive(r[4:3], r[2:0], tag);
  endtask

  // Monitor: results are due half a cycle after the driving edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (node_val !== it.ev || node_lvl !== it.el) begin
        bad++;
        $display("FAIL %s: actual val=%b lvl=%0d expected val=%b lvl=%0d",
                 it.tag, node_val, node_lvl, it.ev, it.el);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);

    // Idle state: all drivers undriven, value bits random
    clear_buf();
    drive(2'b10, 3'd0, "R6 all highz");
    clear_buf();
    drive(2'b10, 3'd0, "R5 highz value bits ignored");

    clear_buf(); put(0, 1'b0, 3'd6); put(1, 1'b1, 3'd5);
    drive(2'b00, 3'd6, "R8 strong0 vs pull1");

    clear_buf(); put(2, 1'b0, 3'd7); put(5, 1'b1, 3'd6);
    drive(2'b00, 3'd7, "R7 supply0 vs strong1");

    clear_buf(); put(3, 1'b1, 3'd7); put(4, 1'b0, 3'd6); put(6, 1'b0, 3'd5);
    drive(2'b01, 3'd7, "R7 supply1 beats all");

    clear_buf(); put(1, 1'b1, 3'd6); put(6, 1'b0, 3'd6);
    drive(2'b11, 3'd6, "R4 strong tie opposite");

    clear_buf(); put(0, 1'b1, 3'd7); put(7, 1'b0, 3'd7);
    drive(2'b11, 3'd7, "R4 supply tie opposite");

    clear_buf(); put(2, 1'b0, 3'd2); put(4, 1'b0, 3'd2); put(5, 1'b1, 3'd2);
    drive(2'b11, 3'd2, "R4 medium three-way tie");

    clear_buf(); put(3, 1'b1, 3'd3); put(7, 1'b1, 3'd3); put(0, 1'b0, 3'd1);
    drive(2'b01, 3'd3, "R3 weak agree");

    clear_buf(); put(4, 1'b1, 3'd1);
    drive(2'b01, 3'd1, "R2 single small charge");

    clear_buf(); put(5, 1'b0, 3'd4); put(2, 1'b1, 3'd3);
    drive(2'b00, 3'd4, "R1 large beats weak");

    clear_buf(); put(6, 1'b1, 3'd5);
    drive(2'b01, 3'd5, "R5 pull over highz");

    clear_buf(); put(0, 1'b1, 3'd6); put(1, 1'b0, 3'd5);
    drive(2'b01, 3'd6, "R9 order A");
    clear_buf(); put(7, 1'b1, 3'd6); put(6, 1'b0, 3'd5);
    drive(2'b01, 3'd6, "R9 order B");

    clear_buf(); put(0, 1'b0, 3'd0); put(1, 1'b1, 3'd0);
    drive(2'b10, 3'd0, "R10 Z code");

    // Random mixes against the pairwise fold, each also with ports reversed
    for (int i = 0; i < 300; i++) begin
      logic [N-1:0]   rv;
      logic [N*3-1:0] rl;
      clear_buf();
      for (int k = 0; k < N; k++) begin
        logic [2:0] lv;
        lv = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 2) == 0) lv = 3'd0;
        put(k, 1'($urandom), lv);
      end
      rv = v_buf;
      rl = l_buf;
      drive_ref("R2 random mix");
      for (int k = 0; k < N; k++) put(N-1-k, rv[k], rl[k*3 +: 3]);
      drive_ref("R9 random reversed");
    end

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule